// File: doc/BRIEF.md
# Dual Edge Pulse Capture Unit

This block timestamps two successive edges of a single input signal against a free-running counter supplied from outside, so that software can measure either the width of a pulse or the period of a waveform. The input is first brought into the clock domain through a two-stage synchronizer. It can then pass through an optional glitch filter with a programmable length. Finally it is compared with its own previous sample to find rising and falling edges.

Two capture slots, first and second, work as a chained pair. Once the unit is enabled and armed, the first selected edge copies the counter into the first slot and raises its flag. Only after that, an edge chosen by the second slot's select copies the counter into the second slot and raises the second flag. Choosing the same edge kind for both slots gives a period. Choosing opposite edges gives a pulse width. In one-shot operation the arm drops after the second capture. In continuous operation the pair keeps repeating. Each flag drives an interrupt through its own enable.

Top module: `pulse_pair_capture`

## Requirements
- R1: After reset, both capture values are zero, both flags, both interrupts and the armed status are 0.
- R2: No capture and no flag change happens while the unit is disabled (mode_en = 0) or not armed. While disabled, arm_set is ignored, and dropping mode_en clears the armed status.
- R3: Each slot's 2-bit select is encoded as 00 no edge, 01 rising, 10 falling, 11 either edge. A slot whose select is 00 never captures.
- R4: While armed, the first edge matching sel_a stores `count` into cap_a and sets flag_a. The next edge matching sel_b stores `count` into cap_b and sets flag_b. The edge that completes the first capture is never also taken by the second slot.
- R5: An edge matching sel_b that arrives before the first capture of the current measurement is ignored.
- R6: With continuous = 0, the armed status clears on the second capture, and further edges are ignored until arm_set is pulsed again.
- R7: With continuous = 1, the armed status stays set after the second capture, and the next matching sel_a edge starts a new measurement.
- R8: irq_a is high exactly when flag_a and ie_a are both 1; irq_b is high exactly when flag_b and ie_b are both 1.
- R9: With filt_len = N > 0, a new synchronized input level is accepted only after it has persisted for N consecutive clocks, so shorter glitches cause no capture. With filt_len = 0, the synchronized input is used unfiltered.
- R10: Pulsing clr_a or clr_b clears the matching flag. If a capture into that slot happens in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| mode_en | input | 1 | Enables dual-edge measurement; 0 clears arm and any pending measurement |
| arm_set | input | 1 | Pulse that arms a measurement |
| continuous | input | 1 | 1 = repeat measurements, 0 = one-shot |
| filt_len | input | 4 | Glitch filter length in clocks; 0 bypasses the filter |
| sel_a | input | 2 | Edge select for the first slot |
| sel_b | input | 2 | Edge select for the second slot |
| ie_a | input | 1 | Interrupt enable for the first slot |
| ie_b | input | 1 | Interrupt enable for the second slot |
| clr_a | input | 1 | Clears flag_a |
| clr_b | input | 1 | Clears flag_b |
| sig_in | input | 1 | Asynchronous signal under measurement |
| count | input | 16 | Free-running timer value |
| cap_a | output | 16 | Counter value latched at the first edge |
| cap_b | output | 16 | Counter value latched at the second edge |
| flag_a | output | 1 | First capture occurred |
| flag_b | output | 1 | Second capture occurred |
| irq_a | output | 1 | First-slot interrupt |
| irq_b | output | 1 | Second-slot interrupt |
| armed | output | 1 | Measurement armed |

## Verification
Two functions can land in the same cycle. One pair is a flag capture and a clear of that same flag. The bench places the clr_a pulse on exactly the clock edge where a bypassed input change reaches the capture stage, three edges after the input moves. It then judges that flag_a stays set and that the scoreboard receives the captured value. The other pair is a single edge that matches both slots' selects, in period and either-edge setups. There the bench expects the edge to go to the first slot only, and it receives the second value from a later edge.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  function automatic logic edge_hit(input edge_sel_e sel, input logic rise, input logic fall);
    logic hit;
    case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/pcap_sync.sv
module pcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pcap_glitch_filter.sv
module pcap_glitch_filter #(
  parameter bit HAS_FILTER = 1'b1,
  parameter int FILT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILT_W-1:0] len,
  input  logic              d,
  output logic              q
);
  logic lvl_q, lvl_d;

  generate
    if (HAS_FILTER) begin : g_filt
      logic [FILT_W-1:0] run_q, run_d;

      always_comb begin
        run_d = '0;
        lvl_d = lvl_q;
        if (len == '0) begin
          lvl_d = d;
        end else if (d != lvl_q) begin
          if (run_q == len - 1'b1) lvl_d = d;
          else                     run_d = run_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
      end
    end else begin : g_bypass
      logic unused_len;
      assign unused_len = ^len;
      always_comb lvl_d = d;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign q = lvl_q;
endmodule

// File: rtl/pcap_edge_detect.sv
module pcap_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/pulse_pair_capture.sv
module pulse_pair_capture
  import pcap_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FILT_W     = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_FILTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic              arm_set,
  input  logic              continuous,
  input  logic [FILT_W-1:0] filt_len,
  input  logic [1:0]        sel_a,
  input  logic [1:0]        sel_b,
  input  logic              ie_a,
  input  logic              ie_b,
  input  logic              clr_a,
  input  logic              clr_b,
  input  logic              sig_in,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  cap_a,
  output logic [CNT_W-1:0]  cap_b,
  output logic              flag_a,
  output logic              flag_b,
  output logic              irq_a,
  output logic              irq_b,
  output logic              armed
);
  logic sync_lvl, filt_lvl, rise, fall;

  pcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sig_in), .q(sync_lvl)
  );

  pcap_glitch_filter #(.HAS_FILTER(HAS_FILTER), .FILT_W(FILT_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .len(filt_len), .d(sync_lvl), .q(filt_lvl)
  );

  pcap_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(filt_lvl), .rise(rise), .fall(fall)
  );

  // measurement state
  logic             armed_q, armed_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cap_a_q, cap_a_d, cap_b_q, cap_b_d;
  logic             flag_a_q, flag_a_d, flag_b_q, flag_b_d;
  logic             run, a_take, b_take;

  assign run    = mode_en & armed_q;
  assign a_take = run & ~pend_q & edge_hit(edge_sel_e'(sel_a), rise, fall);
  assign b_take = run &  pend_q & edge_hit(edge_sel_e'(sel_b), rise, fall);

  always_comb begin
    armed_d  = armed_q;
    pend_d   = pend_q;
    cap_a_d  = cap_a_q;
    cap_b_d  = cap_b_q;
    flag_a_d = flag_a_q & ~clr_a;
    flag_b_d = flag_b_q & ~clr_b;

    if (!mode_en) begin
      armed_d = 1'b0;
      pend_d  = 1'b0;
    end else begin
      if (b_take && !continuous) armed_d = 1'b0;
      else if (arm_set)          armed_d = 1'b1;
      if (a_take)      pend_d = 1'b1;
      else if (b_take) pend_d = 1'b0;
    end

    if (a_take) begin
      cap_a_d  = count;
      flag_a_d = 1'b1;
    end
    if (b_take) begin
      cap_b_d  = count;
      flag_b_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      pend_q   <= 1'b0;
      cap_a_q  <= '0;
      cap_b_q  <= '0;
      flag_a_q <= 1'b0;
      flag_b_q <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      pend_q   <= pend_d;
      cap_a_q  <= cap_a_d;
      cap_b_q  <= cap_b_d;
      flag_a_q <= flag_a_d;
      flag_b_q <= flag_b_d;
    end
  end

  assign cap_a  = cap_a_q;
  assign cap_b  = cap_b_q;
  assign flag_a = flag_a_q;
  assign flag_b = flag_b_q;
  assign irq_a  = flag_a_q & ie_a;
  assign irq_b  = flag_b_q & ie_b;
  assign armed  = armed_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(armed_q) |-> ($stable(cap_a_q) && $stable(cap_b_q)));

  // R5
  second_after_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_b_q) |-> $past(pend_q));

  // R6
  oneshot_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_b_q) && !$past(continuous)) |-> !armed_q);

  // R10
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(a_take) |-> flag_a_q);

  // R4
  first_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_a_q) |-> pend_q);

endmodule

// File: tb/pulse_pair_capture_test.sv
`timescale 1ns/1ps
module pulse_pair_capture_test;
  typedef struct {
    bit          slot;
    logic [15:0] val;
    string       req;
  } exp_t;

  logic clk, rst_n;
  logic mode_en, arm_set, continuous, ie_a, ie_b, clr_a, clr_b, sig_in;
  logic [3:0]  filt_len;
  logic [1:0]  sel_a, sel_b;
  logic [15:0] count, cap_a, cap_b;
  logic flag_a, flag_b, irq_a, irq_b, armed;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t sb[$];

  pulse_pair_capture uut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .arm_set(arm_set),
    .continuous(continuous), .filt_len(filt_len), .sel_a(sel_a), .sel_b(sel_b),
    .ie_a(ie_a), .ie_b(ie_b), .clr_a(clr_a), .clr_b(clr_b), .sig_in(sig_in),
    .count(count), .cap_a(cap_a), .cap_b(cap_b), .flag_a(flag_a), .flag_b(flag_b),
    .irq_a(irq_a), .irq_b(irq_b), .armed(armed)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pop on every flag rise
  bit pa = 1'b0, pb = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (flag_a && !pa) pop_cmp(1'b0, cap_a);
      if (flag_b && !pb) pop_cmp(1'b1, cap_b);
    end
    pa = flag_a;
    pb = flag_b;
  end

  task automatic pop_cmp(input bit slot, input logic [15:0] v);
    exp_t e;
    if (sb.size() == 0) begin
      n_chk++; n_bad++;
      $display("FAIL R2: unexpected capture slot %0d actual %0d expected none", slot, v);
    end else begin
      e = sb.pop_front();
      check({e.req, " slot"}, 16'(slot), 16'(e.slot));
      check({e.req, " value"}, v, e.val);
    end
  endtask

  // driver: set count, move input, push expectation
  task automatic edge_to(input logic lvl, input logic [15:0] cv, input bit want,
                         input bit slot, input string req);
    exp_t e;
    @(negedge clk);
    if (want) begin
      e.slot = slot; e.val = cv; e.req = req;
      sb.push_back(e);
    end
    count  = cv;
    sig_in = lvl;
    repeat (12) @(negedge clk);
  endtask

  task automatic arm;
    @(negedge clk) arm_set = 1'b1;
    @(negedge clk) arm_set = 1'b0;
  endtask

  task automatic clear_flags;
    @(negedge clk) begin clr_a = 1'b1; clr_b = 1'b1; end
    @(negedge clk) begin clr_a = 1'b0; clr_b = 1'b0; end
    check("R10 flag_a cleared", 16'(flag_a), 16'd0);
    check("R10 flag_b cleared", 16'(flag_b), 16'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_en = 1'b0; arm_set = 1'b0; continuous = 1'b0;
    ie_a = 1'b1; ie_b = 1'b1; clr_a = 1'b0; clr_b = 1'b0; sig_in = 1'b0;
    filt_len = 4'd0; sel_a = 2'b01; sel_b = 2'b10; count = 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 cap_a", cap_a, 16'd0);
    check("R1 cap_b", cap_b, 16'd0);
    check("R1 flags", {14'd0, flag_a, flag_b}, 16'd0);
    check("R1 irqs", {14'd0, irq_a, irq_b}, 16'd0);
    check("R1 armed", 16'(armed), 16'd0);

    // R2: disabled, arm ignored, edges ignored
    arm;
    check("R2 arm ignored when disabled", 16'(armed), 16'd0);
    edge_to(1'b1, 16'd10, 0, 0, "R2");
    edge_to(1'b0, 16'd20, 0, 0, "R2");
    mode_en = 1'b1;
    // R2: enabled but not armed
    edge_to(1'b1, 16'd30, 0, 0, "R2");
    edge_to(1'b0, 16'd40, 0, 0, "R2");
    check("R2 no flags unarmed", {14'd0, flag_a, flag_b}, 16'd0);

    // R4 R6 R8: one-shot pulse width
    arm;
    check("R6 armed set", 16'(armed), 16'd1);
    edge_to(1'b1, 16'd100, 1, 0, "R4");
    check("R8 irq_a", 16'(irq_a), 16'd1);
    check("R8 irq_b idle", 16'(irq_b), 16'd0);
    edge_to(1'b0, 16'd150, 1, 1, "R4");
    check("R8 irq_b", 16'(irq_b), 16'd1);
    check("R6 armed cleared", 16'(armed), 16'd0);
    clear_flags;
    edge_to(1'b1, 16'd160, 0, 0, "R6");
    edge_to(1'b0, 16'd170, 0, 0, "R6");
    check("R6 no capture after one-shot", {14'd0, flag_a, flag_b}, 16'd0);

    // R5: second-slot edge before first is ignored
    sel_a = 2'b10; sel_b = 2'b01;
    arm;
    edge_to(1'b1, 16'd200, 0, 0, "R5");
    edge_to(1'b0, 16'd210, 1, 0, "R5");
    edge_to(1'b1, 16'd220, 1, 1, "R5");
    clear_flags;

    // R3 period: same edge on both slots
    sel_a = 2'b01; sel_b = 2'b01;
    arm;
    edge_to(1'b0, 16'd300, 0, 0, "R3");
    edge_to(1'b1, 16'd310, 1, 0, "R3");
    edge_to(1'b0, 16'd320, 0, 0, "R3");
    edge_to(1'b1, 16'd330, 1, 1, "R3");
    clear_flags;

    // R3 select 00 never captures
    sel_a = 2'b00;
    arm;
    edge_to(1'b0, 16'd400, 0, 0, "R3");
    edge_to(1'b1, 16'd410, 0, 0, "R3");
    check("R3 none keeps armed", 16'(armed), 16'd1);
    check("R3 none no flags", {14'd0, flag_a, flag_b}, 16'd0);
    // R3 either edge
    sel_a = 2'b11; sel_b = 2'b11;
    edge_to(1'b0, 16'd420, 1, 0, "R3");
    edge_to(1'b1, 16'd430, 1, 1, "R3");
    clear_flags;

    // R7 continuous
    continuous = 1'b1; sel_a = 2'b01; sel_b = 2'b10;
    arm;
    edge_to(1'b0, 16'd500, 0, 0, "R7");
    edge_to(1'b1, 16'd510, 1, 0, "R7");
    edge_to(1'b0, 16'd520, 1, 1, "R7");
    check("R7 stays armed", 16'(armed), 16'd1);
    clear_flags;
    edge_to(1'b1, 16'd530, 1, 0, "R7");
    edge_to(1'b0, 16'd540, 1, 1, "R7");
    clear_flags;
    continuous = 1'b0;
    @(negedge clk) mode_en = 1'b0;
    @(negedge clk) mode_en = 1'b1;
    check("R2 disable drops arm", 16'(armed), 16'd0);

    // R8 enable off
    ie_a = 1'b0;
    arm;
    edge_to(1'b1, 16'd600, 1, 0, "R8");
    check("R8 flag_a without irq", 16'(flag_a), 16'd1);
    check("R8 irq_a masked", 16'(irq_a), 16'd0);
    edge_to(1'b0, 16'd610, 1, 1, "R8");
    check("R8 irq_b on", 16'(irq_b), 16'd1);
    clear_flags;
    ie_a = 1'b1;

    // R9 glitch filter
    filt_len = 4'd5;
    arm;
    @(negedge clk) sig_in = 1'b1;
    repeat (2) @(negedge clk);
    sig_in = 1'b0;
    repeat (12) @(negedge clk);
    check("R9 short high rejected", 16'(flag_a), 16'd0);
    edge_to(1'b1, 16'd700, 1, 0, "R9");
    @(negedge clk) sig_in = 1'b0;
    repeat (2) @(negedge clk);
    sig_in = 1'b1;
    repeat (12) @(negedge clk);
    check("R9 short low rejected", 16'(flag_b), 16'd0);
    edge_to(1'b0, 16'd710, 1, 1, "R9");
    clear_flags;
    filt_len = 4'd0;

    // R10 clear lands on the capture edge (bypass path: 3 edges)
    arm;
    begin
      exp_t e;
      @(negedge clk);
      e.slot = 1'b0; e.val = 16'd800; e.req = "R10";
      sb.push_back(e);
      count = 16'd800; sig_in = 1'b1;
      repeat (3) @(negedge clk);
      clr_a = 1'b1;
      @(negedge clk) clr_a = 1'b0;
      check("R10 set wins over clear", 16'(flag_a), 16'd1);
      repeat (8) @(negedge clk);
    end
    edge_to(1'b0, 16'd810, 1, 1, "R10");
    clear_flags;

    repeat (20) @(negedge clk);
    check("R4 scoreboard drained", 16'(sb.size()), 16'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule